// File: doc/BRIEF.md
# Serial Register Port with Selectable Read Line

This block is the slave side of a three-wire control port. A host lowers an active-low select, toggles a serial clock and shifts a 16-bit frame into the block. The frame carries a register address, a direction flag and a data byte. Write frames update a small register file of 23 byte-wide locations. Read frames return the addressed byte to the host on one of two lines: the shared data line, which the block then drives, or a dedicated data-out line. Bit 0 of register 14h selects the line.

The block runs on a fast system clock. The select, serial clock and incoming data are sampled on that clock, so they must already be synchronous to it. Edges of the serial clock are found by comparing the sampled level with the level of the previous cycle. Pad drivers sit outside the block. It provides a value and an output enable for each of the two lines it can drive.

Top module: `serial_reg_port`

## Requirements
- R1: A frame is 16 bits sent MSB first, and each bit is captured on a rising edge of the serial clock. The first seven bits are address bits 6..0, the eighth bit is the direction (1 = write, 0 = read), and the last eight bits are data bits 7..0.
- R2: A write updates the addressed register on the 16th rising edge of the frame. The new value can be read in any later frame. Read frames leave every register unchanged.
- R3: If select rises before the 16th rising edge, the frame is discarded and no register changes.
- R4: Writes to addresses above 16h are ignored, and reads from those addresses return 00h.
- R5: Reset sets every register to 00h, clears any frame in progress and turns both output enables off.
- R6: When bit 0 of register 14h is 0, a read drives the shared line. Data bit 7 appears after the first falling edge that follows the direction bit, and each later falling edge, up to the one after the 15th rising edge, presents the next lower bit. The dedicated line stays off.
- R7: When bit 0 of register 14h is 1, a read drives the dedicated line. Data bit 7 appears after the rising edge that captures the direction bit, and the rising edges that capture bits 9 to 15 each present the next lower bit. The shared line stays off.
- R8: Both output enables are off while select is high, while reset is low, and before the direction bit of a read has been captured. The two enables are never on together.
- R9: The read line is chosen by the value of register 14h bit 0 when the direction bit is captured. Clock edges after the 16th rising edge of a frame have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low frame select |
| sck | input | 1 | Serial clock from the host |
| sdio_in | input | 1 | Level received on the shared data line |
| sdio_out | output | 1 | Value to drive onto the shared data line |
| sdio_oe | output | 1 | Output enable for the shared data line |
| sdo_out | output | 1 | Value to drive onto the dedicated data-out line |
| sdo_oe | output | 1 | Output enable for the dedicated data-out line |

## Verification
The hardest case to reach is a change of read line between frames. This needs a write frame that flips register 14h bit 0, followed at once by read frames in the new mode, including a read of register 14h itself. The stimulus alternates write and read frames so that both modes are entered and left. It also checks each read bit in the half of the serial clock where it must be stable, which differs between the two lines. Select is raised part-way through a write, and reset is asserted in the data phase of a read, to show that the enables drop and that nothing is committed.

// File: rtl/serial_reg_port.sv
module serial_reg_port #(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int LAST_ADDR = 22,
  parameter int MODE_ADDR = 20,
  parameter int MODE_BIT  = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic sck,
  input  logic sdio_in,
  output logic sdio_out,
  output logic sdio_oe,
  output logic sdo_out,
  output logic sdo_oe
);

  localparam int FRAME_W = ADDR_W + 1 + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int NREG    = LAST_ADDR + 1;
  localparam logic [CNT_W-1:0]  C_DIR  = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0]  C_DAT0 = CNT_W'(ADDR_W + 1);
  localparam logic [CNT_W-1:0]  C_LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0]  C_FULL = CNT_W'(FRAME_W);
  localparam logic [ADDR_W-1:0] TOP_A  = LAST_ADDR[ADDR_W-1:0];

  logic                sck_q;
  logic [CNT_W-1:0]    cnt;
  logic [FRAME_W-2:0]  sh;
  logic                rd_act, rd_alt;
  logic [DATA_W-1:0]   rd_sh;
  logic                sdio_q, sdio_oe_q, sdo_q, sdo_oe_q;
  logic [DATA_W-1:0]   regs [NREG];

  wire rise = sck & ~sck_q;
  wire fall = ~sck & sck_q;

  wire [ADDR_W-1:0] hdr_addr = sh[ADDR_W-1:0];
  wire [ADDR_W-1:0] wr_addr  = sh[FRAME_W-2 -: ADDR_W];
  wire              wr_dir   = sh[DATA_W-1];
  wire [DATA_W-1:0] wr_data  = {sh[DATA_W-2:0], sdio_in};
  wire [DATA_W-1:0] rd_word  = (hdr_addr <= TOP_A) ? regs[hdr_addr] : '0;
  wire              mode     = regs[MODE_ADDR][MODE_BIT];
  wire              wr_go    = ~sel_n & rise & (cnt == C_LAST) & wr_dir & (wr_addr <= TOP_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_go) begin
      regs[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0; cnt <= '0; sh <= '0;
      rd_act <= 1'b0; rd_alt <= 1'b0; rd_sh <= '0;
      sdio_q <= 1'b0; sdio_oe_q <= 1'b0; sdo_q <= 1'b0; sdo_oe_q <= 1'b0;
    end else begin
      sck_q <= sck;
      if (sel_n) begin
        cnt <= '0; rd_act <= 1'b0;
        sdio_q <= 1'b0; sdio_oe_q <= 1'b0; sdo_q <= 1'b0; sdo_oe_q <= 1'b0;
      end else if (rise && cnt != C_FULL) begin
        cnt <= cnt + 1'b1;
        sh  <= {sh[FRAME_W-3:0], sdio_in};
        if (cnt == C_DIR && !sdio_in) begin
          rd_act <= 1'b1;
          rd_alt <= mode;
          if (mode) begin
            sdo_oe_q <= 1'b1;
            sdo_q    <= rd_word[DATA_W-1];
            rd_sh    <= {rd_word[DATA_W-2:0], 1'b0};
          end else begin
            rd_sh    <= rd_word;
          end
        end else if (rd_act && rd_alt && cnt < C_LAST) begin
          sdo_q <= rd_sh[DATA_W-1];
          rd_sh <= {rd_sh[DATA_W-2:0], 1'b0};
        end
      end else if (fall && rd_act && !rd_alt && cnt >= C_DAT0 && cnt != C_FULL) begin
        sdio_oe_q <= 1'b1;
        sdio_q    <= rd_sh[DATA_W-1];
        rd_sh     <= {rd_sh[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign sdio_oe  = sdio_oe_q & ~sel_n & rst_n;
  assign sdo_oe   = sdo_oe_q & ~sel_n & rst_n;
  assign sdio_out = sdio_q & sdio_oe;
  assign sdo_out  = sdo_q & sdo_oe;

  assert_one_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(sdio_oe_q && sdo_oe_q));
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> (!sdio_oe_q && !sdo_oe_q && cnt == '0));
  assert_no_early_sdo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe_q |-> cnt > C_DIR);
  assert_sdio_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sdio_oe_q && $past(sdio_oe_q) && sdio_q != $past(sdio_q)) |-> $past(fall));
  assert_sdo_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe_q && $past(sdo_oe_q) && sdo_q != $past(sdo_q)) |-> $past(rise));
  assert_mode_reg_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs[MODE_ADDR]) |-> ($past(cnt) == C_LAST && !$past(sel_n)));

endmodule

// File: tb/test_serial_reg_port.sv
module test_serial_reg_port;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1;
  logic sck = 1'b0;
  logic sdio_in = 1'b0;
  logic sdio_out, sdio_oe, sdo_out, sdo_oe;

  int total = 0;
  int bad = 0;
  bit done = 0;

  serial_reg_port i_serial_reg_port (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sck(sck), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo_out(sdo_out), .sdo_oe(sdo_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference model
  int mem [23];
  int m_prev, m_n, m_frame, m_rd, m_alt, m_data;
  int e_sio_oe, e_sio, e_so_oe, e_so;

  function automatic int mem_rd(input int a);
    return (a <= 22) ? mem[a] : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mem[k]) mem[k] = 0;
      m_prev = 0; m_n = 0; m_frame = 0; m_rd = 0; m_alt = 0; m_data = 0;
      e_sio_oe = 0; e_sio = 0; e_so_oe = 0; e_so = 0;
    end else begin
      int r, f;
      r = (sck && !m_prev) ? 1 : 0;
      f = (!sck && m_prev) ? 1 : 0;
      m_prev = sck;
      if (sel_n) begin
        m_n = 0; m_frame = 0; m_rd = 0;
        e_sio_oe = 0; e_sio = 0; e_so_oe = 0; e_so = 0;
      end else if (r && m_n < 16) begin
        m_frame = m_frame * 2 + int'(sdio_in);
        m_n++;
        if (m_n == 8 && !sdio_in) begin
          m_rd = 1;
          m_alt = mem_rd(20) & 1;
          m_data = mem_rd(m_frame >> 1);
          if (m_alt != 0) begin e_so_oe = 1; e_so = (m_data >> 7) & 1; end
        end else if (m_rd != 0 && m_alt != 0 && m_n >= 9 && m_n <= 15) begin
          e_so = (m_data >> (15 - m_n)) & 1;
        end
        if (m_n == 16 && ((m_frame >> 8) & 1) != 0) begin
          int a;
          a = (m_frame >> 9) & 127;
          if (a <= 22) mem[a] = m_frame & 255;
        end
      end else if (f && m_rd != 0 && m_alt == 0 && m_n >= 8 && m_n <= 15) begin
        e_sio_oe = 1;
        e_sio = (m_data >> (15 - m_n)) & 1;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (rst_n) begin
        chk(sdio_oe == e_sio_oe[0], "R6/R8 shared enable", int'(sdio_oe), e_sio_oe);
        chk(sdio_out == (e_sio[0] & e_sio_oe[0]), "R6 shared data", int'(sdio_out), e_sio & e_sio_oe);
        chk(sdo_oe == e_so_oe[0], "R7/R8 dedicated enable", int'(sdo_oe), e_so_oe);
        chk(sdo_out == (e_so[0] & e_so_oe[0]), "R7 dedicated data", int'(sdo_out), e_so & e_so_oe);
      end
    end
  end

  task automatic send_bit(input logic b, output logic so_lo, output logic sio_hi);
    @(negedge clk); sck = 1'b0; sdio_in = b;
    repeat (2) @(negedge clk);
    so_lo = sdo_out; sck = 1'b1;
    repeat (2) @(negedge clk);
    sio_hi = sdio_out;
  endtask

  task automatic frame(input logic [15:0] w, input int nbits, input bit alt, output logic [7:0] got);
    logic lo, hi;
    got = '0;
    @(negedge clk); sel_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      send_bit((i < 16) ? w[15 - i] : 1'b1, lo, hi);
      if (i >= 8 && i < 16) got = {got[6:0], alt ? lo : hi};
    end
    @(negedge clk); sck = 1'b0;
    repeat (2) @(negedge clk);
    sel_n = 1'b1; sdio_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    logic [7:0] g;
    frame({a[6:0], 1'b1, d[7:0]}, 16, 1'b0, g);
  endtask

  task automatic rd(input int a, input bit alt, output logic [7:0] g);
    frame({a[6:0], 1'b0, 8'h00}, 16, alt, g);
  endtask

  initial begin
    logic [7:0] g;
    logic lo, hi;
    repeat (4) @(negedge clk);
    chk(sdio_oe == 0 && sdo_oe == 0, "R5 enables in reset", int'({sdio_oe, sdo_oe}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(sdio_oe == 0 && sdo_oe == 0, "R8 idle enables", int'({sdio_oe, sdo_oe}), 0);
    rd(8'h00, 0, g); chk(g == 8'h00, "R5 reg 00h after reset", g, 8'h00);
    rd(8'h16, 0, g); chk(g == 8'h00, "R5 reg 16h after reset", g, 8'h00);
    // R1 R2 basic write then read on the shared line
    wr(8'h03, 8'hA5);
    rd(8'h03, 0, g); chk(g == 8'hA5, "R1 write/read 03h", g, 8'hA5);
    rd(8'h03, 0, g); chk(g == 8'hA5, "R2 read leaves value", g, 8'hA5);
    wr(8'h16, 8'h3C);
    rd(8'h16, 0, g); chk(g == 8'h3C, "R2 last address", g, 8'h3C);
    // R4 out of range
    wr(8'h17, 8'hFF);
    rd(8'h17, 0, g); chk(g == 8'h00, "R4 read 17h", g, 8'h00);
    rd(8'h7F, 0, g); chk(g == 8'h00, "R4 read 7Fh", g, 8'h00);
    rd(8'h16, 0, g); chk(g == 8'h3C, "R4 16h untouched", g, 8'h3C);
    // R3 aborted write
    frame({7'h05, 1'b1, 8'h5A}, 15, 1'b0, g);
    rd(8'h05, 0, g); chk(g == 8'h00, "R3 aborted write", g, 8'h00);
    // R9 extra edges ignored
    frame({7'h02, 1'b1, 8'h81}, 20, 1'b0, g);
    rd(8'h02, 0, g); chk(g == 8'h81, "R9 extra edges", g, 8'h81);
    // R7 dedicated line
    wr(8'h14, 8'h01);
    rd(8'h03, 1, g); chk(g == 8'hA5, "R7 read 03h dedicated", g, 8'hA5);
    rd(8'h14, 1, g); chk(g == 8'h01, "R7 read 14h dedicated", g, 8'h01);
    rd(8'h02, 1, g); chk(g == 8'h81, "R7 read 02h dedicated", g, 8'h81);
    // R9 back to shared line
    wr(8'h14, 8'h00);
    rd(8'h16, 0, g); chk(g == 8'h3C, "R9 mode back to shared", g, 8'h3C);
    // R8 reset in a read data phase
    @(negedge clk); sel_n = 1'b0;
    for (int i = 0; i < 12; i++) send_bit((i < 7) ? 1'b0 : (i == 6 ? 1'b1 : 1'b0), lo, hi);
    chk(sdio_oe == 1, "R6 enable in data phase", int'(sdio_oe), 1);
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk(sdio_oe == 0 && sdo_oe == 0, "R8 reset drops enables", int'({sdio_oe, sdo_oe}), 0);
    repeat (3) @(negedge clk);
    sel_n = 1'b1; sck = 1'b0; rst_n = 1'b1;
    repeat (2) @(negedge clk);
    rd(8'h03, 0, g); chk(g == 8'h00, "R5 cleared after reset", g, 8'h00);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule